// File: doc/BRIEF.md
# Device Reset Sequencer

This block turns a set of reset initiators into an orderly reset of a large device. Two asynchronous pins start a power-on reset, and an asynchronous warm pin starts a warm reset. Three single-cycle requests (software, watchdog, debug/emulation) are synchronous to the reference clock and start warm resets too. Every warm reset is either hard or soft. A small type register chooses hard or soft for the warm pin, the software request and the watchdog. Emulation requests are always hard. A power-on reset always overrides warm activity.

The block drives three reset domains:
- a power-on-only domain for test, debug and isolated logic;
- the main core domain;
- a retention domain for the memory-controller and PCIe configuration registers, which is held in reset only by power-on and hard resets.

Around these it provides:
- an active-low status output;
- a one-cycle strobe that captures the configuration pins after power-on;
- a clock-pause enable that runs after the status output releases;
- a sticky record of the kind and initiator of the last reset.

A system integrator connects the domain outputs to the reset trees and the pause enable to the clock gating. The device's initialization logic drives `initDone`.

Top module: `rst_seq_top`

## Requirements
- R1: While `porN` or `fullRstN` is low, `porDomRstN`, `coreDomRstN`, `retainDomRstN` and `resetStatN` are all 0. In the same condition the cause record reads kind 0 / initiator 0, and the type register clears to 0, so every initiator acts as hard.
- R2: After the power-on pins release, `porDomRstN` goes high on its own. `coreDomRstN` stays 0 for as long as `warmRstN` is still low, and goes high only after both pins are high.
- R3: `latchedCfg` takes the value of `cfgPins` only when a power-on reset releases, which is marked by a one-cycle `cfgLatch`. Hard and soft resets leave `latchedCfg` unchanged.
- R4: A low pulse on `warmRstN` shorter than MIN_LOW (24) synchronized cycles is ignored. A pulse of 24 cycles or more starts a warm reset.
- R5: By default (type register 0), every warm initiator gives a hard reset, which drives both `coreDomRstN` and `retainDomRstN` low.
- R6: Each type-register bit makes one initiator soft: bit0 the warm pin, bit1 software, bit2 the watchdog. A soft reset drives `coreDomRstN` low and keeps `retainDomRstN` high. Emulation is hard whatever the register holds.
- R7: When warm requests arrive in the same cycle, a hard request wins over a soft one. Among requests of equal kind the order is pin, then software, then watchdog, then emulation.
- R8: `resetStatN` is low while a reset is held. It rises two cycles after `initDone` is seen in the initialization phase, and never before `coreDomRstN` is high.
- R9: `clkPause` is high from the cycle `resetStatN` rises, for PAUSE_LONG (10) cycles after a power-on or hard reset and for PAUSE_SHORT (8) cycles after a soft reset.
- R10: The cause record is updated in the cycle a warm request is accepted and keeps its value until the next reset. Kind codes: 0 power-on, 1 hard, 2 soft. Initiator codes: 0 power-on, 1 pin, 2 software, 3 watchdog, 4 emulation.
- R11: A warm request that arrives while a reset is being held is ignored, and the cause record keeps the initiator that started the hold.
- R12: A power-on reset asserted during a warm reset takes over at once. The cause record becomes power-on, and the configuration pins are captured again when it releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| porN | input | 1 | Asynchronous power-on reset pin, active low |
| fullRstN | input | 1 | Asynchronous full-device reset pin, active low |
| warmRstN | input | 1 | Asynchronous warm reset pin, active low |
| swRstReq | input | 1 | Software reset request, one-cycle pulse |
| wdogRstReq | input | 1 | Watchdog reset request, one-cycle pulse |
| emuRstReq | input | 1 | Emulation reset request, one-cycle pulse |
| cfgWe | input | 1 | Write enable for the reset-type register |
| cfgData | input | 3 | New reset-type register value (1 = soft) |
| cfgPins | input | CFG_W | Device configuration pins |
| initDone | input | 1 | Device initialization complete |
| porDomRstN | output | 1 | Power-on-only domain reset, active low |
| coreDomRstN | output | 1 | Main device domain reset, active low |
| retainDomRstN | output | 1 | Retained-register domain reset, active low |
| resetStatN | output | 1 | Reset status, low while in reset |
| cfgLatch | output | 1 | One-cycle configuration capture strobe |
| latchedCfg | output | CFG_W | Captured configuration pins |
| clkPause | output | 1 | System clock pause enable |
| causeKind | output | 2 | Kind of the last reset |
| causeSrc | output | 3 | Initiator of the last reset |

## Verification
Simultaneous warm requests of mixed kind are hardest to reach, because the warm pin becomes a request only after its filter count expires. The table therefore uses the single-cycle software, watchdog and emulation requests to collide initiators in one cycle, with type-register values that mix hard and soft. The filter threshold is approached from both sides with pulses of 23 and 24 cycles. A full-reset pulse is placed inside a soft hold to show that power-on takes over and clears the type register.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam int NUM_WARM = 4;   // pin, software, watchdog, emulation

  typedef enum logic [1:0] {
    RT_POWER = 2'd0,
    RT_HARD  = 2'd1,
    RT_SOFT  = 2'd2
  } rstKind_e;

  typedef enum logic [2:0] {
    SRC_POWER = 3'd0,
    SRC_PIN   = 3'd1,
    SRC_SW    = 3'd2,
    SRC_WDOG  = 3'd3,
    SRC_EMU   = 3'd4
  } rstSrc_e;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_INIT  = 2'd1,
    ST_PAUSE = 2'd2,
    ST_RUN   = 2'd3
  } seqState_e;

  // strobes from the sequencer control to the output datapath
  typedef struct packed {
    logic     holdCore;
    logic     holdRetain;
    logic     statRel;
    logic     pause;
    logic     latchCfg;
    logic     record;
    rstKind_e recKind;
    rstSrc_e  recSrc;
  } seqStrobe_t;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RST_VAL;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int MIN_LOW     = 24,
  parameter int HOLD_CYC    = 16,
  parameter int PAUSE_LONG  = 10,
  parameter int PAUSE_SHORT = 8
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       warmSync,
  input  logic       swReq,
  input  logic       wdogReq,
  input  logic       emuReq,
  input  logic [2:0] softCfg,
  input  logic       initDone,
  output seqStrobe_t strobe
);
  localparam int LOW_W   = $clog2(MIN_LOW + 1);
  localparam int HOLD_W  = $clog2(HOLD_CYC + 1);
  localparam int PAUSE_W = $clog2(PAUSE_LONG + 1);

  seqState_e          state;
  rstKind_e           curKind;
  logic [LOW_W-1:0]   lowCnt;
  logic [HOLD_W-1:0]  holdCnt;
  logic [PAUSE_W-1:0] pauseCnt;

  // warm pin low-time filter
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                          lowCnt <= '0;
    else if (warmSync)                     lowCnt <= '0;
    else if (lowCnt != LOW_W'(MIN_LOW))    lowCnt <= lowCnt + 1'b1;
  end

  logic warmQual;
  assign warmQual = (lowCnt == LOW_W'(MIN_LOW));

  // arbitration: hard over soft, then lowest index
  logic [NUM_WARM-1:0] reqVec, softMask, hardVec, pickVec;
  logic [1:0]          pickIdx;
  rstKind_e            pickKind;
  rstSrc_e             pickSrc;

  assign reqVec   = {emuReq, wdogReq, swReq, warmQual};
  assign softMask = {1'b0, softCfg[2], softCfg[1], softCfg[0]};
  assign hardVec  = reqVec & ~softMask;
  assign pickVec  = (|hardVec) ? hardVec : reqVec;
  assign pickKind = (|hardVec) ? RT_HARD : RT_SOFT;

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_WARM - 1; i >= 0; i--) begin
      if (pickVec[i]) pickIdx = i[1:0];
    end
  end

  assign pickSrc = rstSrc_e'({1'b0, pickIdx} + 3'd1);

  logic accept, holdDone, exitHold, pauseLast;
  int   pauseLen;

  assign accept    = (state != ST_HOLD) && (|reqVec);
  assign holdDone  = (holdCnt == HOLD_W'(HOLD_CYC));
  assign exitHold  = (state == ST_HOLD) && holdDone && warmSync;
  assign pauseLen  = (curKind == RT_SOFT) ? PAUSE_SHORT : PAUSE_LONG;
  assign pauseLast = (pauseCnt == PAUSE_W'(pauseLen - 1));

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state    <= ST_HOLD;
      curKind  <= RT_POWER;
      holdCnt  <= '0;
      pauseCnt <= '0;
    end else if (accept) begin
      state   <= ST_HOLD;
      curKind <= pickKind;
      holdCnt <= '0;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (!holdDone)     holdCnt <= holdCnt + 1'b1;
          else if (warmSync) state   <= ST_INIT;
        end
        ST_INIT: begin
          if (initDone) begin
            state    <= ST_PAUSE;
            pauseCnt <= '0;
          end
        end
        ST_PAUSE: begin
          if (pauseLast) state    <= ST_RUN;
          else           pauseCnt <= pauseCnt + 1'b1;
        end
        ST_RUN: ;
        default: state <= ST_HOLD;
      endcase
    end
  end

  always_comb begin
    strobe.holdCore   = (state == ST_HOLD);
    strobe.holdRetain = (state == ST_HOLD) && (curKind != RT_SOFT);
    strobe.statRel    = (state == ST_PAUSE) || (state == ST_RUN);
    strobe.pause      = (state == ST_PAUSE);
    strobe.latchCfg   = exitHold && (curKind == RT_POWER);
    strobe.record     = accept;
    strobe.recKind    = pickKind;
    strobe.recSrc     = pickSrc;
  end
endmodule

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             porRstN,
  input  seqStrobe_t       strobe,
  input  logic             cfgWe,
  input  logic [2:0]       cfgData,
  input  logic [CFG_W-1:0] cfgPins,
  output logic [2:0]       softCfg,
  output logic             porDomRstN,
  output logic             coreDomRstN,
  output logic             retainDomRstN,
  output logic             resetStatN,
  output logic             cfgLatch,
  output logic [CFG_W-1:0] latchedCfg,
  output logic             clkPause,
  output logic [1:0]       causeKind,
  output logic [2:0]       causeSrc
);
  // domain outputs, registered from the strobes
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      porDomRstN    <= 1'b0;
      coreDomRstN   <= 1'b0;
      retainDomRstN <= 1'b0;
      resetStatN    <= 1'b0;
      clkPause      <= 1'b0;
      cfgLatch      <= 1'b0;
    end else begin
      porDomRstN    <= 1'b1;
      coreDomRstN   <= !strobe.holdCore;
      retainDomRstN <= !strobe.holdRetain;
      resetStatN    <= strobe.statRel;
      clkPause      <= strobe.pause;
      cfgLatch      <= strobe.latchCfg;
    end
  end

  // configuration pin capture
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)             latchedCfg <= '0;
    else if (strobe.latchCfg) latchedCfg <= cfgPins;
  end

  // reset-type register, survives warm resets
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)   softCfg <= '0;
    else if (cfgWe) softCfg <= cfgData;
  end

  // sticky cause record
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      causeKind <= RT_POWER;
      causeSrc  <= SRC_POWER;
    end else if (strobe.record) begin
      causeKind <= strobe.recKind;
      causeSrc  <= strobe.recSrc;
    end
  end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int CFG_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 24,
  parameter int HOLD_CYC    = 16,
  parameter int PAUSE_LONG  = 10,
  parameter int PAUSE_SHORT = 8
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             fullRstN,
  input  logic             warmRstN,
  input  logic             swRstReq,
  input  logic             wdogRstReq,
  input  logic             emuRstReq,
  input  logic             cfgWe,
  input  logic [2:0]       cfgData,
  input  logic [CFG_W-1:0] cfgPins,
  input  logic             initDone,
  output logic             porDomRstN,
  output logic             coreDomRstN,
  output logic             retainDomRstN,
  output logic             resetStatN,
  output logic             cfgLatch,
  output logic [CFG_W-1:0] latchedCfg,
  output logic             clkPause,
  output logic [1:0]       causeKind,
  output logic [2:0]       causeSrc
);
  import rst_seq_pkg::*;

  logic       porAnyN, porRstN, warmSync;
  logic [2:0] softCfg;
  seqStrobe_t strobe;

  assign porAnyN = porN & fullRstN;

  rst_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) porSync_i (
    .clk(clk), .rstN(porAnyN), .d(1'b1), .q(porRstN)
  );

  rst_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) warmSync_i (
    .clk(clk), .rstN(porRstN), .d(warmRstN), .q(warmSync)
  );

  rst_seq_ctrl #(
    .MIN_LOW(MIN_LOW), .HOLD_CYC(HOLD_CYC),
    .PAUSE_LONG(PAUSE_LONG), .PAUSE_SHORT(PAUSE_SHORT)
  ) ctrl_i (
    .clk(clk), .porRstN(porRstN), .warmSync(warmSync),
    .swReq(swRstReq), .wdogReq(wdogRstReq), .emuReq(emuRstReq),
    .softCfg(softCfg), .initDone(initDone), .strobe(strobe)
  );

  rst_seq_dp #(.CFG_W(CFG_W)) dp_i (
    .clk(clk), .porRstN(porRstN), .strobe(strobe),
    .cfgWe(cfgWe), .cfgData(cfgData), .cfgPins(cfgPins),
    .softCfg(softCfg),
    .porDomRstN(porDomRstN), .coreDomRstN(coreDomRstN),
    .retainDomRstN(retainDomRstN), .resetStatN(resetStatN),
    .cfgLatch(cfgLatch), .latchedCfg(latchedCfg), .clkPause(clkPause),
    .causeKind(causeKind), .causeSrc(causeSrc)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int CFG_W      = 8,
  parameter int PAUSE_LONG = 10
) (
  input logic             clk,
  input logic             porRstN,
  input logic             coreDomRstN,
  input logic             retainDomRstN,
  input logic             resetStatN,
  input logic             cfgLatch,
  input logic [CFG_W-1:0] latchedCfg,
  input logic             clkPause,
  input logic [1:0]       causeKind,
  input logic             initDone
);
  localparam int RUN_W = $clog2(PAUSE_LONG + 2);
  logic [RUN_W-1:0] pauseRun;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)      pauseRun <= '0;
    else if (clkPause) pauseRun <= pauseRun + 1'b1;
    else               pauseRun <= '0;
  end

  p_status_after_core_r8: assert property (@(posedge clk) disable iff (!porRstN)
    resetStatN |-> coreDomRstN);

  p_status_waits_init_r8: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(resetStatN) |-> $past(initDone, 2));

  p_soft_keeps_retain_r6: assert property (@(posedge clk) disable iff (!porRstN)
    (causeKind == 2'd2) |-> retainDomRstN);

  p_pause_bound_r9: assert property (@(posedge clk) disable iff (!porRstN)
    clkPause |-> (pauseRun < RUN_W'(PAUSE_LONG)));

  p_latch_pulse_r3: assert property (@(posedge clk) disable iff (!porRstN)
    cfgLatch |=> !cfgLatch);

  p_latch_only_on_strobe_r3: assert property (@(posedge clk) disable iff (!porRstN)
    !cfgLatch |-> $stable(latchedCfg));

  p_warm_cause_r10: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(coreDomRstN) |-> (causeKind != 2'd0));
endmodule

bind rst_seq_top rst_seq_chk #(.CFG_W(CFG_W), .PAUSE_LONG(PAUSE_LONG)) chk_i (
  .clk(clk), .porRstN(porRstN), .coreDomRstN(coreDomRstN),
  .retainDomRstN(retainDomRstN), .resetStatN(resetStatN),
  .cfgLatch(cfgLatch), .latchedCfg(latchedCfg), .clkPause(clkPause),
  .causeKind(causeKind), .initDone(initDone)
);

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       porN, fullRstN, warmRstN;
  logic       swRstReq, wdogRstReq, emuRstReq, cfgWe, initDone;
  logic [2:0] cfgData;
  logic [7:0] cfgPins, latchedCfg;
  logic       porDomRstN, coreDomRstN, retainDomRstN, resetStatN, cfgLatch, clkPause;
  logic [1:0] causeKind;
  logic [2:0] causeSrc;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;   // 250 MHz

  rst_seq_top dut_i (
    .clk(clk), .porN(porN), .fullRstN(fullRstN), .warmRstN(warmRstN),
    .swRstReq(swRstReq), .wdogRstReq(wdogRstReq), .emuRstReq(emuRstReq),
    .cfgWe(cfgWe), .cfgData(cfgData), .cfgPins(cfgPins), .initDone(initDone),
    .porDomRstN(porDomRstN), .coreDomRstN(coreDomRstN),
    .retainDomRstN(retainDomRstN), .resetStatN(resetStatN),
    .cfgLatch(cfgLatch), .latchedCfg(latchedCfg), .clkPause(clkPause),
    .causeKind(causeKind), .causeSrc(causeSrc)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp=<60000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // row: cfg[15:13] req{emu,wdog,sw}[12:10] kind[9:8] src[7:5] retainDrop[4] pause[3:0]
  localparam logic [15:0] VEC [9] = '{
    {3'b000, 3'b001, 2'd1, 3'd2, 1'b1, 4'd10},
    {3'b010, 3'b001, 2'd2, 3'd2, 1'b0, 4'd8 },
    {3'b100, 3'b010, 2'd2, 3'd3, 1'b0, 4'd8 },
    {3'b000, 3'b010, 2'd1, 3'd3, 1'b1, 4'd10},
    {3'b111, 3'b100, 2'd1, 3'd4, 1'b1, 4'd10},
    {3'b000, 3'b111, 2'd1, 3'd2, 1'b1, 4'd10},
    {3'b010, 3'b011, 2'd1, 3'd3, 1'b1, 4'd10},
    {3'b110, 3'b111, 2'd1, 3'd4, 1'b1, 4'd10},
    {3'b110, 3'b011, 2'd2, 3'd2, 1'b0, 4'd8 }
  };

  task automatic writeCfg(input logic [2:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgData = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic waitCoreLow();
    for (int k = 0; k < 40 && coreDomRstN; k++) @(negedge clk);
  endtask

  // follow a reset to the end of its pause; returns retain-low flag and pause length
  task automatic finishReset(output bit retainLow, output int pauseN);
    retainLow = 1'b0;
    pauseN = 0;
    for (int k = 0; k < 400 && !resetStatN; k++) begin
      if (!retainDomRstN) retainLow = 1'b1;
      @(negedge clk);
    end
    for (int k = 0; k < 50 && clkPause; k++) begin
      pauseN++;
      @(negedge clk);
    end
  endtask

  task automatic runRow(input logic [15:0] v);
    bit    rl;
    int    pn;
    string tag;
    tag = (v[9:8] == 2'd2) ? "R6" : (($countones(v[12:10]) > 1) ? "R7" : "R5");
    writeCfg(v[15:13]);
    {emuRstReq, wdogRstReq, swRstReq} = v[12:10];
    @(negedge clk);
    {emuRstReq, wdogRstReq, swRstReq} = 3'b000;
    waitCoreLow();
    check(!coreDomRstN, tag, coreDomRstN, 0);
    check(causeKind == v[9:8], {tag, " R10 kind"}, causeKind, v[9:8]);
    check(causeSrc == v[7:5], {tag, " R10 src"}, causeSrc, v[7:5]);
    finishReset(rl, pn);
    check(rl == v[4], {tag, " retain"}, rl, v[4]);
    check(pn == v[3:0], "R9 pause", pn, v[3:0]);
  endtask

  task automatic pinPulse(input int len);
    @(negedge clk); warmRstN = 1'b0;
    repeat (len) @(negedge clk);
    warmRstN = 1'b1;
  endtask

  initial begin
    bit rl;
    int pn;
    bit dropped;
    porN = 1'b0; fullRstN = 1'b1; warmRstN = 1'b1;
    swRstReq = 0; wdogRstReq = 0; emuRstReq = 0;
    cfgWe = 0; cfgData = 3'b000; cfgPins = 8'hA5; initDone = 1'b0;

    repeat (5) @(negedge clk);
    // R1 reset state
    check(!porDomRstN && !coreDomRstN && !retainDomRstN && !resetStatN, "R1 outputs",
          {porDomRstN, coreDomRstN, retainDomRstN, resetStatN}, 0);
    check(causeKind == 0 && causeSrc == 0, "R1 cause", {causeKind, causeSrc}, 0);

    // R2: warm pin still low when power-on releases
    warmRstN = 1'b0;
    @(negedge clk); porN = 1'b1;
    repeat (40) @(negedge clk);
    check(porDomRstN, "R2 por domain", porDomRstN, 1);
    check(!coreDomRstN, "R2 core held", coreDomRstN, 0);
    check(latchedCfg == 8'h00, "R3 not yet captured", latchedCfg, 0);
    cfgPins = 8'h3C;
    warmRstN = 1'b1;
    for (int k = 0; k < 60 && !coreDomRstN; k++) @(negedge clk);
    check(coreDomRstN, "R2 core release", coreDomRstN, 1);
    check(latchedCfg == 8'h3C, "R3 capture", latchedCfg, 8'h3C);

    // R8: status waits for initDone
    repeat (20) @(negedge clk);
    check(!resetStatN, "R8 held", resetStatN, 0);
    initDone = 1'b1;
    @(negedge clk);
    check(!resetStatN, "R8 one cycle", resetStatN, 0);
    @(negedge clk);
    check(resetStatN, "R8 rise", resetStatN, 1);
    pn = 0;
    for (int k = 0; k < 50 && clkPause; k++) begin pn++; @(negedge clk); end
    check(pn == 10, "R9 power-on pause", pn, 10);

    // table of warm requests
    cfgPins = 8'hFF;
    foreach (VEC[i]) begin
      runRow(VEC[i]);
      repeat (5) @(negedge clk);
    end
    check(latchedCfg == 8'h3C, "R3 no recapture", latchedCfg, 8'h3C);

    // R4: warm pin filter at the threshold
    writeCfg(3'b000);
    pinPulse(23);
    dropped = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (!coreDomRstN) dropped = 1'b1;
      @(negedge clk);
    end
    check(!dropped, "R4 short pulse", dropped, 0);
    check(causeSrc == 3'd2, "R4 cause kept", causeSrc, 2);
    pinPulse(24);
    waitCoreLow();
    check(!coreDomRstN, "R4 threshold", coreDomRstN, 0);
    check(causeKind == 2'd1 && causeSrc == 3'd1, "R5 pin hard", {causeKind, causeSrc}, 9);
    finishReset(rl, pn);
    check(rl, "R5 pin retain drop", rl, 1);

    // R6: pin made soft
    writeCfg(3'b001);
    pinPulse(30);
    waitCoreLow();
    check(causeKind == 2'd2 && causeSrc == 3'd1, "R6 pin soft", {causeKind, causeSrc}, 17);
    finishReset(rl, pn);
    check(!rl && pn == 8, "R6 pin soft retain/pause", {rl, pn[3:0]}, 8);

    // R11: request during a hold is ignored
    writeCfg(3'b000);
    @(negedge clk); swRstReq = 1'b1;
    @(negedge clk); swRstReq = 1'b0;
    repeat (4) @(negedge clk);
    wdogRstReq = 1'b1;
    @(negedge clk); wdogRstReq = 1'b0;
    finishReset(rl, pn);
    check(causeSrc == 3'd2, "R11 ignored", causeSrc, 2);
    repeat (50) @(negedge clk);
    check(causeKind == 2'd1 && causeSrc == 3'd2, "R10 sticky", {causeKind, causeSrc}, 10);

    // R12: power-on takes over a soft hold
    writeCfg(3'b111);
    cfgPins = 8'h81;
    @(negedge clk); swRstReq = 1'b1;
    @(negedge clk); swRstReq = 1'b0;
    repeat (3) @(negedge clk);
    fullRstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!porDomRstN && !retainDomRstN, "R12 takeover", {porDomRstN, retainDomRstN}, 0);
    check(causeKind == 0 && causeSrc == 0, "R12 cause", {causeKind, causeSrc}, 0);
    fullRstN = 1'b1;
    finishReset(rl, pn);
    check(latchedCfg == 8'h81, "R12 R3 recapture", latchedCfg, 8'h81);
    @(negedge clk); swRstReq = 1'b1;
    @(negedge clk); swRstReq = 1'b0;
    waitCoreLow();
    check(causeKind == 2'd1, "R1 type register cleared", causeKind, 1);
    finishReset(rl, pn);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule